// File: doc/BRIEF.md
# Timer Channel Compare/Capture Unit

This block is a single channel of a general-purpose timer. It watches the value of a shared free-running counter, supplied from outside together with the counter's modulo (terminal) value. Depending on a 4-bit mode field, it does one of three things. It can drive an output pin on compare matches, as a level action or a one-cycle pulse. It can produce an edge-aligned PWM waveform with a selectable active level. It can also latch the counter into its channel value register when a chosen edge arrives on the input pin.

Each match or capture sets a sticky event flag, which can raise an interrupt request. An external trigger can gate the output pin. When gating is on and the selected trigger is low, the pin is forced to the channel's idle level. A polarity control inverts both the pin input and the pin output. Software changes the mode by writing the field and polling the readback. The readback only returns the new field once the change has taken effect.

Top module: `timer_channel`

## Requirements
- R1: During and right after synchronous reset, `pin_out`, `flag`, `irq`, `ctrl_rdata` and `val_rdata` are all 0.
- R2: A write on `ctrl_wr` takes effect two clock edges later. `ctrl_rdata` shows the old field one cycle after the write and the new field two cycles after it. It never shows the new field before the logic uses it.
- R3: Mode field bits [3:2]=01 selects output compare. A match (`cnt_val` equal to the channel value) acts on the pin according to bits [1:0]: 00 hold, 01 toggle, 10 drive 0, 11 drive 1. The pin follows one cycle after the counter value.
- R4: Bits [3:2]=11 selects pulse output. Field 1101 makes the pin 1 only in the cycle after a match and 0 otherwise. Field 1110 makes it 0 only after a match and 1 otherwise.
- R5: Bits [3:2]=10 selects edge-aligned PWM. The raw level is active while `cnt_val` is below the channel value. Field 1010 is high-true, 10x1 is low-true, and 1000 holds the pin at 0. A value of 0 never goes active, and a value above `mod_val` is always active.
- R6: In PWM mode a new channel value is applied only at the counter period end (`cnt_val` equal to `mod_val`), so it first affects the count of 0 that follows. In the other modes it applies two cycles after the write.
- R7: Bits [3:2]=00 with non-zero bits [1:0] selects input capture. Edge select 01 captures on a rising edge, 10 on a falling edge and 11 on either edge. The input passes through a two-flop synchroniser. The counter value present two cycles after the pin change is loaded, and it appears on `val_rdata` and as a set `flag` three cycles after the pin change.
- R8: `flag` is set by a match in compare, PWM or pulse modes and by a capture. A `flag_clr` pulse clears it one cycle later, but a simultaneous set wins. `irq` is `flag` masked by `irq_en`, and both update in the same cycle.
- R9: Even channel indices use `trig_in[0]` and odd ones use `trig_in[1]`. With `trig_gate_en` high and the selected trigger low, the pin shows the idle level instead of the waveform. The idle level is 1 for low-true PWM and for field 1110, and 0 otherwise. The other trigger bit has no effect.
- R10: `pol_inv` inverts the pin output after gating, and inverts the pin input before edge detection.
- R11: Field 0000 disables the channel: the pin stays 0 (before polarity) and matches set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Shared counter value |
| mod_val | input | CNT_W | Counter terminal value (period end) |
| ctrl_wr | input | 1 | Write strobe for the mode field |
| ctrl_wdata | input | 4 | Mode field: [3:2] mode, [1:0] edge/level |
| ctrl_rdata | output | 4 | Mode field currently in effect |
| val_wr | input | 1 | Write strobe for the channel value |
| val_wdata | input | CNT_W | Channel value to write |
| val_rdata | output | CNT_W | Channel value register (written or captured) |
| pin_in | input | 1 | Channel input pin (capture source) |
| trig_in | input | 2 | Trigger inputs, bit picked by channel index parity |
| trig_gate_en | input | 1 | Enables output gating by the selected trigger |
| pol_inv | input | 1 | Inverts pin input and output |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-1 clear of the event flag |
| pin_out | output | 1 | Channel output pin (registered) |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a compare value written in the middle of a PWM period. The new value has to be held back until the period end, while the counter keeps moving. The bench drives the counter itself, one value per cycle. It writes the new duty at a chosen count and keeps its own record of the value in force, swapping that record only after driving the terminal count. The edge-to-capture latency is made observable by holding the counter at a known constant during each pin transition. For the polarity test on capture, the polarity is changed while the channel is disabled, so the synchroniser settles before the capture mode is armed.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  typedef enum logic [1:0] {
    MS_CAPT  = 2'b00,
    MS_CMP   = 2'b01,
    MS_PWM   = 2'b10,
    MS_PULSE = 2'b11
  } ch_mode_e;

  // Level the pin rests at when the trigger gate holds it off.
  function automatic logic idle_level(input logic [3:0] f);
    return ((f[3:2] == MS_PWM) && f[0]) ||
           ((f[3:2] == MS_PULSE) && (f[1:0] == 2'b10));
  endfunction
endpackage

// File: rtl/tc_regs.sv
`timescale 1ns/1ps
module tc_regs
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [3:0]       ctrl_wdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             cap_stb,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] mod_val,
  output logic [3:0]       ctrl_act,
  output logic [CNT_W-1:0] val_q,
  output logic [CNT_W-1:0] cmp_act
);
  logic       pend_v;
  logic [3:0] pend_f;
  logic       period_end;

  assign period_end = (cnt_val == mod_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      pend_f   <= '0;
      ctrl_act <= '0;
      val_q    <= '0;
      cmp_act  <= '0;
    end else begin
      // mode field: staged one cycle, then made active; readback is the active copy
      pend_v <= ctrl_wr;
      if (ctrl_wr) pend_f <= ctrl_wdata;
      if (pend_v) ctrl_act <= pend_f;
      // channel value: software write has priority over a capture
      if (val_wr) val_q <= val_wdata;
      else if (cap_stb) val_q <= cnt_val;
      // compare copy: PWM only reloads at the period end
      if ((ctrl_act[3:2] != MS_PWM) || period_end) cmp_act <= val_q;
    end
  end
endmodule

// File: rtl/tc_capture.sv
`timescale 1ns/1ps
module tc_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       pol_inv,
  input  logic       arm,
  input  logic [1:0] edge_sel,
  output logic       cap_stb
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in ^ pol_inv};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl     = sync_q[SYNC_STAGES-1];
  assign rise    = lvl & ~prev_q;
  assign fall    = ~lvl & prev_q;
  assign cap_stb = arm & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
endmodule

// File: rtl/tc_output.sv
`timescale 1ns/1ps
module tc_output
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ctrl,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             gate_en,
  input  logic             trig_lvl,
  input  logic             pol_inv,
  output logic             match,
  output logic             pin_q
);
  ch_mode_e   ms;
  logic [1:0] el;
  logic       st_q;
  logic       st_next;
  logic       below;
  logic       out_lvl;

  assign ms    = ch_mode_e'(ctrl[3:2]);
  assign el    = ctrl[1:0];
  assign match = (cnt_val == cmp_act);
  assign below = (cnt_val < cmp_act);

  always_comb begin
    st_next = st_q;
    case (ms)
      MS_CAPT: st_next = 1'b0;
      MS_CMP: begin
        if (match) begin
          case (el)
            2'b01:   st_next = ~st_q;
            2'b10:   st_next = 1'b0;
            2'b11:   st_next = 1'b1;
            default: st_next = st_q;
          endcase
        end
      end
      MS_PWM: begin
        if (el == 2'b00) st_next = 1'b0;
        else if (el == 2'b10) st_next = below;
        else st_next = ~below;
      end
      MS_PULSE: begin
        if (el == 2'b01) st_next = match;
        else if (el == 2'b10) st_next = ~match;
        else st_next = 1'b0;
      end
      default: st_next = 1'b0;
    endcase
  end

  assign out_lvl = (gate_en && !trig_lvl) ? idle_level(ctrl) : st_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      st_q  <= st_next;
      pin_q <= out_lvl ^ pol_inv;
    end
  end
endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
  import tc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CH_INDEX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             ctrl_wr,
  input  logic [3:0]       ctrl_wdata,
  output logic [3:0]       ctrl_rdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [CNT_W-1:0] val_rdata,
  input  logic             pin_in,
  input  logic [1:0]       trig_in,
  input  logic             trig_gate_en,
  input  logic             pol_inv,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             flag,
  output logic             irq
);
  localparam bit ODD_CH = (CH_INDEX % 2) != 0;

  logic [3:0]       ctrl_act;
  logic [CNT_W-1:0] cmp_act;
  logic             cap_stb;
  logic             match;
  logic             trig_lvl;
  logic             set_evt;
  logic             flag_n;
  logic             flag_q;
  logic             irq_q;

  assign trig_lvl = ODD_CH ? trig_in[1] : trig_in[0];

  tc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .val_wr(val_wr), .val_wdata(val_wdata),
    .cap_stb(cap_stb), .cnt_val(cnt_val), .mod_val(mod_val),
    .ctrl_act(ctrl_act), .val_q(val_rdata), .cmp_act(cmp_act)
  );

  tc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst(rst),
    .pin_in(pin_in), .pol_inv(pol_inv),
    .arm(ctrl_act[3:2] == MS_CAPT), .edge_sel(ctrl_act[1:0]),
    .cap_stb(cap_stb)
  );

  tc_output #(.CNT_W(CNT_W)) u_output (
    .clk(clk), .rst(rst),
    .ctrl(ctrl_act), .cnt_val(cnt_val), .cmp_act(cmp_act),
    .gate_en(trig_gate_en), .trig_lvl(trig_lvl), .pol_inv(pol_inv),
    .match(match), .pin_q(pin_out)
  );

  assign set_evt = ((ctrl_act[3:2] != MS_CAPT) && match) || cap_stb;
  assign flag_n  = set_evt | (flag_q & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n & irq_en;
    end
  end

  assign ctrl_rdata = ctrl_act;
  assign flag       = flag_q;
  assign irq        = irq_q;
endmodule

// File: rtl/timer_channel_chk.sv
`timescale 1ns/1ps
module timer_channel_chk #(
  parameter int CH_INDEX = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_wr,
  input logic [3:0] ctrl_rdata,
  input logic [1:0] trig_in,
  input logic       trig_gate_en,
  input logic       pol_inv,
  input logic       irq_en,
  input logic       pin_out,
  input logic       flag,
  input logic       irq
);
  localparam bit ODD_CH = (CH_INDEX % 2) != 0;

  logic sel_trig;
  logic rst_seen_q = 1'b0;

  assign sel_trig = ODD_CH ? trig_in[1] : trig_in[0];

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: one edge after a reset cycle every output is quiet
  always_ff @(posedge clk) begin
    if (rst_seen_q)
      assert_reset_quiet_R1: assert (!flag && !irq && !pin_out && ctrl_rdata == 4'b0000)
        else $error("reset state not clean");
  end

  // R2: readback only moves two cycles after a write
  assert_rdback_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_wr) |=> $stable(ctrl_rdata));

  // R11: disabled channel raises no flag
  assert_idle_no_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata == 4'b0000 && !flag) |=> !flag);

  // R8: interrupt masked by its enable
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R8: interrupt never without the flag
  assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R9: gated high-true PWM rests low
  assert_gate_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (trig_gate_en && !sel_trig && !pol_inv && ctrl_rdata == 4'b1010) |=> !pin_out);
endmodule

bind timer_channel timer_channel_chk #(.CH_INDEX(CH_INDEX)) u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rdata(ctrl_rdata),
  .trig_in(trig_in), .trig_gate_en(trig_gate_en), .pol_inv(pol_inv),
  .irq_en(irq_en), .pin_out(pin_out), .flag(flag), .irq(irq)
);

// File: tb/test_timer_channel.sv
`timescale 1ns/1ps
module test_timer_channel;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt_val = '0;
  logic [CW-1:0] mod_val = 16'd9;
  logic          ctrl_wr = 1'b0;
  logic [3:0]    ctrl_wdata = '0;
  logic [3:0]    ctrl_rdata;
  logic          val_wr = 1'b0;
  logic [CW-1:0] val_wdata = '0;
  logic [CW-1:0] val_rdata;
  logic          pin_in = 1'b0;
  logic [1:0]    trig_in = 2'b00;
  logic          trig_gate_en = 1'b0;
  logic          pol_inv = 1'b0;
  logic          irq_en = 1'b0;
  logic          flag_clr = 1'b0;
  logic          pin_out;
  logic          flag;
  logic          irq;

  always #2.5 clk = ~clk;

  timer_channel #(.CNT_W(CW), .CH_INDEX(0)) i_timer_channel (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .mod_val(mod_val),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .val_wr(val_wr), .val_wdata(val_wdata), .val_rdata(val_rdata),
    .pin_in(pin_in), .trig_in(trig_in), .trig_gate_en(trig_gate_en),
    .pol_inv(pol_inv), .irq_en(irq_en), .flag_clr(flag_clr),
    .pin_out(pin_out), .flag(flag), .irq(irq)
  );

  // scoreboard item: which output, when, what value
  typedef struct {
    int          due;
    int          sig;
    logic [31:0] exp;
    string       tag;
  } item_t;

  localparam int S_PIN = 0, S_FLAG = 1, S_CTRL = 2, S_VAL = 3, S_IRQ = 4;

  item_t       sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] act;
  logic [3:0]  cur_ctrl = 4'b0000;
  int          eff = 0;
  int          shadow = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] probe(input int s);
    case (s)
      S_PIN:   return {31'd0, pin_out};
      S_FLAG:  return {31'd0, flag};
      S_CTRL:  return {28'd0, ctrl_rdata};
      S_VAL:   return {16'd0, val_rdata};
      default: return {31'd0, irq};
    endcase
  endfunction

  // monitor: compares every item due in this cycle, away from the clock edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        n_chk++;
        act = probe(sb[i].sig);
        if (act !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s: signal %0d actual %0h expected %0h", sb[i].tag, sb[i].sig, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push(input int s, input logic [31:0] v, input int lat, input string tag);
    item_t it;
    it.due = cyc + lat;
    it.sig = s;
    it.exp = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ctrl_wr  = 1'b0;
    val_wr   = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) tick();
  endtask

  // R2: old field one cycle after the write, new field two cycles after
  task automatic set_ctrl(input logic [3:0] f);
    ctrl_wr    = 1'b1;
    ctrl_wdata = f;
    push(S_CTRL, {28'd0, cur_ctrl}, 1, "R2 readback old");
    push(S_CTRL, {28'd0, f}, 2, "R2 readback new");
    cur_ctrl = f;
    ticks(2);
  endtask

  task automatic set_val(input int v);
    val_wr    = 1'b1;
    val_wdata = v[CW-1:0];
    push(S_VAL, v, 1, "R6 value write");
    shadow = v;
    ticks(2);
  endtask

  task automatic cnt_chk(input int c, input logic e, input string tag);
    cnt_val = c[CW-1:0];
    push(S_PIN, {31'd0, e}, 1, tag);
    tick();
  endtask

  // one PWM period per loop pass; optional value write at count wr_c of the first period
  task automatic pwm_run(input int periods, input bit inv, input int wr_c, input int wr_v, input string tag);
    for (int p = 0; p < periods; p++) begin
      for (int c = 0; c <= 9; c++) begin
        if (p == 0 && c == wr_c) begin
          val_wr    = 1'b1;
          val_wdata = wr_v[CW-1:0];
          shadow    = wr_v;
        end
        cnt_val = c[CW-1:0];
        push(S_PIN, {31'd0, ((c < eff) ? 1'b1 : 1'b0) ^ inv}, 1, tag);
        if (c == 9) eff = shadow;
        tick();
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    ticks(3);
    // R1 reset state
    push(S_PIN, 0, 0, "R1 reset pin");
    push(S_FLAG, 0, 0, "R1 reset flag");
    push(S_IRQ, 0, 0, "R1 reset irq");
    push(S_CTRL, 0, 0, "R1 reset field");
    push(S_VAL, 0, 0, "R1 reset value");
    tick();
    rst = 1'b0;
    tick();

    // R3 compare toggle, value 5
    set_ctrl(4'b0101);
    set_val(5);
    cnt_chk(3, 1'b0, "R3 toggle no match");
    cnt_chk(4, 1'b0, "R3 toggle no match");
    cnt_val = 16'd5;
    push(S_FLAG, 1, 1, "R8 flag on match");
    push(S_IRQ, 0, 1, "R8 irq masked");
    cnt_chk(5, 1'b1, "R3 toggle up");
    cnt_chk(6, 1'b1, "R3 toggle hold");
    cnt_chk(5, 1'b0, "R3 toggle down");
    set_ctrl(4'b0111);
    cnt_chk(5, 1'b1, "R3 set on match");
    set_ctrl(4'b0100);
    cnt_chk(5, 1'b1, "R3 none holds");
    set_ctrl(4'b0110);
    cnt_chk(4, 1'b1, "R3 clear no match");
    cnt_chk(5, 1'b0, "R3 clear on match");

    // R8 flag clear and priority
    irq_en = 1'b1;
    flag_clr = 1'b1;
    cnt_val = 16'd5;
    push(S_FLAG, 1, 1, "R8 set wins over clear");
    push(S_IRQ, 1, 1, "R8 irq follows flag");
    tick();
    flag_clr = 1'b1;
    cnt_val = 16'd0;
    push(S_FLAG, 0, 1, "R8 clear");
    push(S_IRQ, 0, 1, "R8 irq clear");
    tick();

    // R4 pulses
    set_ctrl(4'b1101);
    cnt_chk(4, 1'b0, "R4 high pulse idle");
    cnt_chk(5, 1'b1, "R4 high pulse");
    cnt_chk(6, 1'b0, "R4 high pulse end");
    set_ctrl(4'b1110);
    cnt_chk(4, 1'b1, "R4 low pulse idle");
    cnt_chk(5, 1'b0, "R4 low pulse");
    cnt_chk(6, 1'b1, "R4 low pulse end");

    // R5 / R6 PWM
    set_val(4);
    eff = 4;
    set_ctrl(4'b1010);
    pwm_run(2, 1'b0, 2, 7, "R6 PWM buffered update");
    pwm_run(1, 1'b0, 3, 0, "R5 PWM high-true");
    pwm_run(1, 1'b0, -1, 0, "R5 PWM duty zero");
    pwm_run(1, 1'b0, 3, 10, "R5 PWM duty zero");
    pwm_run(1, 1'b0, -1, 0, "R5 PWM duty full");
    set_ctrl(4'b1001);
    pwm_run(1, 1'b1, 4, 4, "R5 PWM low-true full");
    pwm_run(1, 1'b1, -1, 0, "R5 PWM low-true");
    set_ctrl(4'b1000);
    cnt_chk(0, 1'b0, "R5 PWM no output");
    cnt_chk(3, 1'b0, "R5 PWM no output");

    // R9 trigger gating, channel 0 uses bit 0
    set_ctrl(4'b1001);
    trig_gate_en = 1'b1;
    trig_in = 2'b00;
    cnt_chk(0, 1'b1, "R9 gated idle high");
    trig_in = 2'b10;
    cnt_chk(0, 1'b1, "R9 other trigger ignored");
    trig_in = 2'b01;
    cnt_chk(0, 1'b0, "R9 trigger passes");
    trig_in = 2'b00;
    set_ctrl(4'b0111);
    cnt_chk(4, 1'b0, "R9 gated compare");
    trig_in = 2'b01;
    cnt_chk(6, 1'b1, "R9 compare released");
    trig_gate_en = 1'b0;
    trig_in = 2'b00;

    // R10 output polarity
    pol_inv = 1'b1;
    set_ctrl(4'b1010);
    pwm_run(1, 1'b1, -1, 0, "R10 output inverted");
    pol_inv = 1'b0;

    // R7 capture
    set_ctrl(4'b0000);
    flag_clr = 1'b1;
    tick();
    cnt_val = 16'd33;
    set_ctrl(4'b0001);
    pin_in = 1'b1;
    push(S_VAL, 33, 3, "R7 rising capture");
    push(S_FLAG, 1, 3, "R7 capture flag");
    ticks(4);
    flag_clr = 1'b1;
    tick();
    cnt_val = 16'd40;
    pin_in = 1'b0;
    push(S_VAL, 33, 3, "R7 falling ignored");
    push(S_FLAG, 0, 3, "R7 falling ignored");
    ticks(4);
    set_ctrl(4'b0010);
    cnt_val = 16'd50;
    pin_in = 1'b1;
    push(S_VAL, 33, 3, "R7 rising ignored");
    push(S_FLAG, 0, 3, "R7 rising ignored");
    ticks(4);
    pin_in = 1'b0;
    push(S_VAL, 50, 3, "R7 falling capture");
    push(S_FLAG, 1, 3, "R7 falling flag");
    ticks(4);
    flag_clr = 1'b1;
    tick();
    set_ctrl(4'b0011);
    cnt_val = 16'd60;
    pin_in = 1'b1;
    push(S_VAL, 60, 3, "R7 both edges rise");
    ticks(4);
    cnt_val = 16'd61;
    pin_in = 1'b0;
    push(S_VAL, 61, 3, "R7 both edges fall");
    ticks(4);

    // R10 input polarity: change it while disabled, then arm rising capture
    set_ctrl(4'b0000);
    pol_inv = 1'b1;
    ticks(4);
    set_ctrl(4'b0001);
    cnt_val = 16'd70;
    pin_in = 1'b1;
    push(S_VAL, 61, 3, "R10 inverted input no capture");
    ticks(4);
    cnt_val = 16'd71;
    pin_in = 1'b0;
    push(S_VAL, 71, 3, "R10 inverted input capture");
    ticks(4);
    set_ctrl(4'b0000);
    pol_inv = 1'b0;
    ticks(4);

    // R11 disabled channel
    flag_clr = 1'b1;
    push(S_FLAG, 0, 1, "R11 flag cleared");
    tick();
    cnt_val = 16'd71;
    push(S_FLAG, 0, 1, "R11 match ignored");
    cnt_chk(71, 1'b0, "R11 pin idle");
    cnt_chk(72, 1'b0, "R11 pin idle");

    ticks(5);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule